// File: doc/BRIEF.md
# Tracking Output Voltage Window Monitor

This block supervises a regulated output rail. It takes a digitized differential output-voltage sample and compares it with a reference that moves with the regulation target. The reference is the commanded voltage code, limited to a programmable floor and ceiling, plus a signed droop code. Four programmable offsets set the levels around that reference: a fault and a warning level above it, and a fault and a warning level below it. A fifth comparison checks the sample against a fixed absolute over-voltage threshold that does not depend on the reference.

A comparison only produces a flag once it has held for a qualification time. Fault levels need a shorter time than warning levels. Each flag is a single-cycle pulse for a downstream response controller, and it is issued once for each episode of its condition. The block also outputs the limited command code and gives a warning pulse when the limit engages.

Voltage codes have a 1 mV step. Offset codes have an 8 mV step. The ADC, the droop calculation and the DAC are outside the block.

Top module: `vout_window_mon`

## Requirements
- R1: The tracking reference is the limited command code plus `droop_i`, which is read as a two's-complement value. All tracking thresholds move with this reference.
- R2: Over-voltage fault. An offset code of N means 8·N mV, clipped to the range 32 to 448 mV. The condition is `vsense_i` > reference + fault offset, and it must hold for FLT_CYC consecutive clock edges (100 by default, 1 µs at 100 MHz).
- R3: Over-voltage warning. The condition is `vsense_i` > reference + warning offset. The offset uses the same 8 mV step, clipped to 24 to 448 mV, and the condition must hold for WRN_CYC consecutive edges (200 by default).
- R4: Under-voltage fault. The condition is `vsense_i` < reference − fault offset, with the offset clipped to 32 to 448 mV, held for FLT_CYC edges.
- R5: Under-voltage warning. The condition is `vsense_i` < reference − warning offset, with the offset clipped to 24 to 448 mV, held for WRN_CYC edges.
- R6: A single non-violating sample restarts that condition's qualification count from zero.
- R7: While `conv_en_i` is low, no tracking flag pulses and the tracking counts are cleared.
- R8: Fixed over-voltage fault. The condition is `vsense_i` > `fix_thr_i`, with the threshold clipped to 600 to 3700 mV, held for FLT_CYC edges. It is checked whether or not `conv_en_i` is high.
- R9: `vcmd_o` is the command clipped to [`vmin_i`, `vmax_i`], registered with one cycle of delay. If the command is above both limits' window in both directions (the limits overlap), the ceiling wins.
- R10: While `conv_en_i` is high, `clamp_wrn_o` pulses in the cycle after the first edge at which the command is out of limits.
- R11: Each flag is high for exactly one cycle for each episode of its condition. It re-arms only after the condition has been false on at least one edge.
- R12: During reset, all flags are 0 and `vcmd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_en_i | input | 1 | Power conversion active |
| vsense_i | input | VW | Sensed differential output voltage, 1 mV/LSB |
| cmd_i | input | VW | Commanded voltage code |
| droop_i | input | VW | Signed droop code, 1 mV/LSB |
| vmin_i | input | VW | Command floor |
| vmax_i | input | VW | Command ceiling |
| ov_flt_ofs_i | input | OW | Over-voltage fault offset, 8 mV/LSB |
| ov_wrn_ofs_i | input | OW | Over-voltage warning offset, 8 mV/LSB |
| uv_flt_ofs_i | input | OW | Under-voltage fault offset, 8 mV/LSB |
| uv_wrn_ofs_i | input | OW | Under-voltage warning offset, 8 mV/LSB |
| fix_thr_i | input | VW | Fixed over-voltage threshold |
| vcmd_o | output | VW | Limited command code |
| trk_ov_flt_o | output | 1 | Tracking over-voltage fault pulse |
| trk_ov_wrn_o | output | 1 | Tracking over-voltage warning pulse |
| trk_uv_flt_o | output | 1 | Tracking under-voltage fault pulse |
| trk_uv_wrn_o | output | 1 | Tracking under-voltage warning pulse |
| fix_ov_flt_o | output | 1 | Fixed over-voltage fault pulse |
| clamp_wrn_o | output | 1 | Command limit warning pulse |

## Verification
Some properties are checked by assertions on every cycle:
- every flag lasts a single cycle;
- tracking flags stay silent while conversion is off;
- the limited command stays between the limits it was given;
- a fixed fault only follows a sample above the lowest legal threshold;
- a limit warning only follows an out-of-range command.

Other behaviour only the directed scenarios can show:
- the exact qualification delays;
- the restart of a count after a single good sample;
- the offset clipping at both ends;
- the threshold movement caused by droop;
- re-arming after a condition clears.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  typedef enum int {
    F_OVF = 0,
    F_OVW = 1,
    F_UVF = 2,
    F_UVW = 3,
    F_FIX = 4,
    F_CLP = 5
  } flag_e;
  localparam int NFLAG = 6;
  localparam int NCMP  = 5;
endpackage

// File: rtl/vwm_qual.sv
module vwm_qual #(
  parameter int LIM = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LIM + 1);
  logic [CW-1:0] cnt_q;
  logic          fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_o <= 1'b0;
    end else if (!cond_i) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_o <= 1'b0;
    end else if (!fired_q && cnt_q == CW'(LIM - 1)) begin
      fired_q <= 1'b1;
      pulse_o <= 1'b1;
    end else begin
      if (!fired_q) cnt_q <= cnt_q + 1'b1;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vwm_clamp.sv
module vwm_clamp #(
  parameter int VW = 12
) (
  input  logic [VW-1:0] cmd_i,
  input  logic [VW-1:0] vmin_i,
  input  logic [VW-1:0] vmax_i,
  output logic [VW-1:0] cmd_o,
  output logic          clip_o
);
  always_comb begin
    clip_o = 1'b1;
    if (cmd_i > vmax_i)      cmd_o = vmax_i;  // ceiling wins on overlap
    else if (cmd_i < vmin_i) cmd_o = vmin_i;
    else begin
      cmd_o  = cmd_i;
      clip_o = 1'b0;
    end
  end
endmodule

// File: rtl/vwm_thresh.sv
module vwm_thresh #(
  parameter int VW      = 12,
  parameter int OW      = 6,
  parameter int FLT_MIN = 4,
  parameter int WRN_MIN = 3,
  parameter int OFS_MAX = 56,
  parameter int FIX_MIN = 600,
  parameter int FIX_MAX = 3700
) (
  input  logic [VW-1:0]         vsense_i,
  input  logic [VW-1:0]         ref_cmd_i,
  input  logic signed [VW-1:0]  droop_i,
  input  logic                  en_i,
  input  logic [OW-1:0]         ov_flt_ofs_i,
  input  logic [OW-1:0]         ov_wrn_ofs_i,
  input  logic [OW-1:0]         uv_flt_ofs_i,
  input  logic [OW-1:0]         uv_wrn_ofs_i,
  input  logic [VW-1:0]         fix_thr_i,
  output logic [vwm_pkg::NCMP-1:0] cond_o
);
  import vwm_pkg::*;
  localparam int SW = VW + 3;
  localparam int PW = SW - OW - 3;

  function automatic logic signed [SW-1:0] ofs_mv(input logic [OW-1:0] c, input int lo);
    logic [OW-1:0] s;
    if (c < OW'(lo))           s = OW'(lo);
    else if (c > OW'(OFS_MAX)) s = OW'(OFS_MAX);
    else                       s = c;
    return $signed({{PW{1'b0}}, s, 3'b000});
  endfunction

  logic signed [SW-1:0] ref_s, vs_s;
  logic [VW-1:0]        fix_thr;

  always_comb begin
    ref_s = $signed({3'b000, ref_cmd_i}) + $signed({{3{droop_i[VW-1]}}, droop_i});
    vs_s  = $signed({3'b000, vsense_i});
    if (fix_thr_i < VW'(FIX_MIN))      fix_thr = VW'(FIX_MIN);
    else if (fix_thr_i > VW'(FIX_MAX)) fix_thr = VW'(FIX_MAX);
    else                               fix_thr = fix_thr_i;
    cond_o[F_OVF] = en_i && (vs_s > ref_s + ofs_mv(ov_flt_ofs_i, FLT_MIN));
    cond_o[F_OVW] = en_i && (vs_s > ref_s + ofs_mv(ov_wrn_ofs_i, WRN_MIN));
    cond_o[F_UVF] = en_i && (vs_s < ref_s - ofs_mv(uv_flt_ofs_i, FLT_MIN));
    cond_o[F_UVW] = en_i && (vs_s < ref_s - ofs_mv(uv_wrn_ofs_i, WRN_MIN));
    cond_o[F_FIX] = vsense_i > fix_thr;
  end
endmodule

// File: rtl/vout_window_mon.sv
module vout_window_mon #(
  parameter int VW      = 12,
  parameter int OW      = 6,
  parameter int FLT_CYC = 100,
  parameter int WRN_CYC = 200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 conv_en_i,
  input  logic [VW-1:0]        vsense_i,
  input  logic [VW-1:0]        cmd_i,
  input  logic signed [VW-1:0] droop_i,
  input  logic [VW-1:0]        vmin_i,
  input  logic [VW-1:0]        vmax_i,
  input  logic [OW-1:0]        ov_flt_ofs_i,
  input  logic [OW-1:0]        ov_wrn_ofs_i,
  input  logic [OW-1:0]        uv_flt_ofs_i,
  input  logic [OW-1:0]        uv_wrn_ofs_i,
  input  logic [VW-1:0]        fix_thr_i,
  output logic [VW-1:0]        vcmd_o,
  output logic                 trk_ov_flt_o,
  output logic                 trk_ov_wrn_o,
  output logic                 trk_uv_flt_o,
  output logic                 trk_uv_wrn_o,
  output logic                 fix_ov_flt_o,
  output logic                 clamp_wrn_o
);
  import vwm_pkg::*;

  function automatic int lim_of(input int k);
    return (k == F_CLP) ? 1 : (k == F_OVW || k == F_UVW) ? WRN_CYC : FLT_CYC;
  endfunction

  logic [VW-1:0]    cmd_lim;
  logic             clip;
  logic [NCMP-1:0]  cmp;
  logic [NFLAG-1:0] cond, flag;

  vwm_clamp #(.VW(VW)) u_clamp (
    .cmd_i  (cmd_i),
    .vmin_i (vmin_i),
    .vmax_i (vmax_i),
    .cmd_o  (cmd_lim),
    .clip_o (clip)
  );

  vwm_thresh #(.VW(VW), .OW(OW)) u_thresh (
    .vsense_i     (vsense_i),
    .ref_cmd_i    (cmd_lim),
    .droop_i      (droop_i),
    .en_i         (conv_en_i),
    .ov_flt_ofs_i (ov_flt_ofs_i),
    .ov_wrn_ofs_i (ov_wrn_ofs_i),
    .uv_flt_ofs_i (uv_flt_ofs_i),
    .uv_wrn_ofs_i (uv_wrn_ofs_i),
    .fix_thr_i    (fix_thr_i),
    .cond_o       (cmp)
  );

  assign cond = {conv_en_i & clip, cmp};

  for (genvar k = 0; k < NFLAG; k++) begin : g_qual
    vwm_qual #(.LIM(lim_of(k))) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cond_i  (cond[k]),
      .pulse_o (flag[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vcmd_o <= '0;
    else         vcmd_o <= cmd_lim;
  end

  assign trk_ov_flt_o = flag[F_OVF];
  assign trk_ov_wrn_o = flag[F_OVW];
  assign trk_uv_flt_o = flag[F_UVF];
  assign trk_uv_wrn_o = flag[F_UVW];
  assign fix_ov_flt_o = flag[F_FIX];
  assign clamp_wrn_o  = flag[F_CLP];
endmodule

// File: rtl/vwm_chk.sv
module vwm_chk #(
  parameter int VW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          conv_en_i,
  input logic [VW-1:0] vsense_i,
  input logic [VW-1:0] cmd_i,
  input logic [VW-1:0] vmin_i,
  input logic [VW-1:0] vmax_i,
  input logic [VW-1:0] vcmd_o,
  input logic          trk_ov_flt_o,
  input logic          trk_ov_wrn_o,
  input logic          trk_uv_flt_o,
  input logic          trk_uv_wrn_o,
  input logic          fix_ov_flt_o,
  input logic          clamp_wrn_o
);
  logic [5:0] fl;
  assign fl = {clamp_wrn_o, fix_ov_flt_o, trk_uv_wrn_o, trk_uv_flt_o, trk_ov_wrn_o, trk_ov_flt_o};

  a_r11_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl != '0) |=> ((fl & $past(fl)) == '0));

  a_r7_gated_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_en_i |=> !(trk_ov_flt_o || trk_ov_wrn_o || trk_uv_flt_o || trk_uv_wrn_o));

  a_r9_in_limits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmin_i <= vmax_i) |=> (vcmd_o <= $past(vmax_i) && vcmd_o >= $past(vmin_i)));

  a_r8_fix_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_ov_flt_o |-> ($past(vsense_i) > VW'(599)));

  a_r10_clamp_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_wrn_o |-> $past(conv_en_i && (cmd_i > vmax_i || cmd_i < vmin_i)));
endmodule

bind vout_window_mon vwm_chk #(.VW(VW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_en_i    (conv_en_i),
  .vsense_i     (vsense_i),
  .cmd_i        (cmd_i),
  .vmin_i       (vmin_i),
  .vmax_i       (vmax_i),
  .vcmd_o       (vcmd_o),
  .trk_ov_flt_o (trk_ov_flt_o),
  .trk_ov_wrn_o (trk_ov_wrn_o),
  .trk_uv_flt_o (trk_uv_flt_o),
  .trk_uv_wrn_o (trk_uv_wrn_o),
  .fix_ov_flt_o (fix_ov_flt_o),
  .clamp_wrn_o  (clamp_wrn_o)
);

// File: tb/vout_window_mon_tb.sv
`timescale 1ns/1ps
module vout_window_mon_tb;
  localparam int VW = 12, OW = 6, FLT = 100, WRN = 200;
  localparam int OVF = 0, OVW = 1, UVF = 2, UVW = 3, FIX = 4, CLP = 5;

  logic clk = 1'b0, rst_n = 1'b0, en;
  logic [VW-1:0] vs, cmd, vmin, vmax, fthr, vcmd;
  logic signed [VW-1:0] droop;
  logic [OW-1:0] ovf_o, ovw_o, uvf_o, uvw_o;
  logic [5:0] fl;
  int total = 0, bad = 0;
  int first_at[6];
  int n_pulse[6];

  always #5 clk = ~clk;

  vout_window_mon #(.VW(VW), .OW(OW), .FLT_CYC(FLT), .WRN_CYC(WRN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_en_i(en), .vsense_i(vs), .cmd_i(cmd),
    .droop_i(droop), .vmin_i(vmin), .vmax_i(vmax), .ov_flt_ofs_i(ovf_o),
    .ov_wrn_ofs_i(ovw_o), .uv_flt_ofs_i(uvf_o), .uv_wrn_ofs_i(uvw_o),
    .fix_thr_i(fthr), .vcmd_o(vcmd), .trk_ov_flt_o(fl[0]), .trk_ov_wrn_o(fl[1]),
    .trk_uv_flt_o(fl[2]), .trk_uv_wrn_o(fl[3]), .fix_ov_flt_o(fl[4]),
    .clamp_wrn_o(fl[5])
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic watch(input int n);
    for (int k = 0; k < 6; k++) begin first_at[k] = 0; n_pulse[k] = 0; end
    for (int c = 1; c <= n; c++) begin
      @(posedge clk); #1;
      for (int k = 0; k < 6; k++)
        if (fl[k]) begin
          n_pulse[k]++;
          if (first_at[k] == 0) first_at[k] = c;
        end
    end
  endtask

  task automatic exp_flag(input int k, input int at, input int cnt, input string req);
    chk(n_pulse[k] == cnt, req, n_pulse[k], cnt);
    if (cnt > 0) chk(first_at[k] == at, req, first_at[k], at);
  endtask

  task automatic nominal();
    en = 1; vs = 1000; cmd = 1000; droop = 0; vmin = 500; vmax = 2000;
    ovf_o = 8; ovw_o = 4; uvf_o = 8; uvw_o = 4; fthr = 3000;
    watch(5);
  endtask

  task automatic t_reset();
    chk(fl == 6'd0, "R12 flags", int'(fl), 0);
    chk(vcmd == 0, "R12 vcmd", int'(vcmd), 0);
  endtask

  task automatic t_quiet();
    nominal();
    vs = 1000; watch(300);
    chk(n_pulse.sum() == 0, "R2 nominal no flags", n_pulse.sum(), 0);
    chk(vcmd == 1000, "R9 pass-through", int'(vcmd), 1000);
  endtask

  task automatic t_ov();
    nominal();
    vs = 1040; watch(300);
    exp_flag(OVW, WRN, 1, "R3 ov warn");
    exp_flag(OVF, 0, 0, "R2 below fault level");
    vs = 1070; watch(300);
    exp_flag(OVF, FLT, 1, "R2 ov fault");
    exp_flag(OVW, 0, 0, "R11 no repeat warn");
    vs = 1000; watch(5);
    vs = 1070; watch(300);
    exp_flag(OVF, FLT, 1, "R11 rearm fault");
    exp_flag(OVW, WRN, 1, "R11 rearm warn");
  endtask

  task automatic t_uv();
    nominal();
    vs = 930; watch(300);
    exp_flag(UVF, FLT, 1, "R4 uv fault");
    exp_flag(UVW, WRN, 1, "R5 uv warn");
    nominal();
    vs = 960; watch(300);
    exp_flag(UVW, WRN, 1, "R5 uv warn only");
    exp_flag(UVF, 0, 0, "R4 above fault level");
  endtask

  task automatic t_droop();
    nominal();
    droop = -12'sd50; vs = 1000; watch(300);
    exp_flag(OVW, WRN, 1, "R1 droop shifts warn");
    exp_flag(OVF, 0, 0, "R1 droop fault clear");
  endtask

  task automatic t_glitch();
    nominal();
    vs = 1070; watch(99);
    exp_flag(OVF, 0, 0, "R6 before limit");
    vs = 1000; watch(1);
    vs = 1070; watch(150);
    exp_flag(OVF, FLT, 1, "R6 count restarted");
  endtask

  task automatic t_ofs_clip();
    nominal();
    ovf_o = 0; ovw_o = 0; vs = 1032; watch(250);
    exp_flag(OVF, 0, 0, "R2 min offset 32");
    exp_flag(OVW, WRN, 1, "R3 min offset 24");
    vs = 1000; watch(5);
    vs = 1033; watch(150);
    exp_flag(OVF, FLT, 1, "R2 min offset edge");
    nominal();
    ovf_o = 63; ovw_o = 63; vs = 1448; watch(250);
    exp_flag(OVF, 0, 0, "R2 max offset 448");
    exp_flag(OVW, 0, 0, "R3 max offset 448");
    vs = 1449; watch(250);
    exp_flag(OVF, FLT, 1, "R2 max offset edge");
    exp_flag(OVW, WRN, 1, "R3 max offset edge");
  endtask

  task automatic t_gate();
    nominal();
    en = 0; vs = 1070; watch(300);
    chk(n_pulse[OVF] + n_pulse[OVW] == 0, "R7 gated ov", n_pulse[OVF] + n_pulse[OVW], 0);
    en = 1; watch(150);
    exp_flag(OVF, FLT, 1, "R7 count from enable");
    nominal();
    en = 0; vs = 900; watch(300);
    chk(n_pulse[UVF] + n_pulse[UVW] == 0, "R7 gated uv", n_pulse[UVF] + n_pulse[UVW], 0);
  endtask

  task automatic t_fix();
    nominal();
    en = 0; fthr = 100; vs = 601; watch(150);
    exp_flag(FIX, FLT, 1, "R8 floor 600 trips");
    vs = 600; watch(150);
    exp_flag(FIX, 0, 0, "R8 at floor");
    nominal();
    fthr = 4000; cmd = 2000; vmax = 4000; vs = 3700; watch(150);
    exp_flag(FIX, 0, 0, "R8 ceiling 3700");
    vs = 3701; watch(150);
    exp_flag(FIX, FLT, 1, "R8 above ceiling");
  endtask

  task automatic t_clamp();
    nominal();
    vs = 2000; cmd = 2500; watch(10);
    exp_flag(CLP, 1, 1, "R10 clamp high warn");
    chk(vcmd == 2000, "R9 clamp high", int'(vcmd), 2000);
    vs = 1000; cmd = 1000; watch(2);
    chk(vcmd == 1000, "R9 release", int'(vcmd), 1000);
    vs = 500; cmd = 100; watch(3);
    exp_flag(CLP, 1, 1, "R10 clamp low rearm");
    chk(vcmd == 500, "R9 clamp low", int'(vcmd), 500);
    vmin = 1500; vmax = 1200; cmd = 1300; watch(2);
    chk(vcmd == 1200, "R9 ceiling priority", int'(vcmd), 1200);
    nominal();
    en = 0; cmd = 2500; watch(5);
    exp_flag(CLP, 0, 0, "R10 gated");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    en = 1; vs = 1000; cmd = 1000; droop = 0; vmin = 500; vmax = 2000;
    ovf_o = 8; ovw_o = 4; uvf_o = 8; uvw_o = 4; fthr = 3000;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_quiet();
    t_ov();
    t_uv();
    t_droop();
    t_glitch();
    t_ofs_clip();
    t_gate();
    t_fix();
    t_clamp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule